// File: doc/BRIEF.md
# Skewed-Wavefront Chamfer Distance Pass Array

This block is a row of processing elements, one per image column, that applies a two-neighbour chamfer distance propagation to an N by N image. Every element owns one column. A result for image position (x, y) depends on two values from the column to its left: the one in the row above (diagonal, weight 4 by default) and the one in the same row (straight, weight 3 by default). Each element finds that minimum with two add-then-compare stages, one per clock. A result moves one element to the right per clock. Work follows a diagonal wavefront: column x handles row y at step x + y.

A launch sequencer inside the block issues a frame of four passes one after the other. Each element takes a new row every clock, so pass p + 1 enters column 0 while pass p is still moving through the later columns. No element ever holds two pixels in one stage. The block tells each element which pass and row it must load: `issue_vld`, `issue_pass` and `issue_row`, skewed by one clock per column. The surrounding frame store answers in the same clock on `pix_in`. Each result leaves tagged with its pass and row, so a consumer can put the skewed results back in raster order. Pixel values are unsigned. 0 marks background and the all-ones value marks an object pixel not yet reached. Any other value is taken as a distance already known.

Top module: `dt_pass_array`

## Requirements
- R1: After reset, no element issues a request (`issue_vld` all 0) and no result is valid (`dist_vld` all 0).
- R2: A `go` sampled while idle makes column 0 request pass 0 row 0 on the next clock. It then requests rows 0 to N-1 of passes 0, 1, 2 and 3 on consecutive clocks: 4N requests with no gap. After that, all requests stop. Every one of the 4N·N positions yields exactly one result.
- R3: Column x (x ≥ 1) requests the same valid/pass/row that column x-1 requested one clock earlier. The row tag is field `issue_row[x*RW +: RW]`, with RW = clog2(N). The pass tag is `issue_pass[x*2 +: 2]`.
- R4: The result for pass p, row y, column x is valid two clocks after that column's request. It therefore appears 2 + x + pN + y clock edges after the edge that sampled `go`, and carries the same pass and row tags.
- R5: The result equals min(pixel, left-upper result + DIAG_W, left result + ORTH_W). Both neighbour results come from the same pass.
- R6: A neighbour outside the image (column 0, or row 0 for the diagonal) counts as the all-ones value. So a column-0 result always equals its own pixel.
- R7: Neighbour sums saturate at the all-ones value (255 for 8-bit values) and never wrap.
- R8: The first row of a pass never takes a neighbour value from the last row of the previous pass.
- R9: `go` is ignored while a frame is being issued. The request order of R2 continues unchanged.
- R10: The last result of a frame (column N-1, pass 3, row N-1) is valid exactly 5N clock edges after the edge that sampled `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a four-pass frame (ignored while running) |
| pix_in | input | N*W | Per-column pixel answering this clock's request; column x at [x*W +: W] |
| issue_vld | output | N | Per-column request strobe |
| issue_pass | output | N*2 | Per-column pass tag of the request |
| issue_row | output | N*clog2(N) | Per-column row tag of the request |
| dist_vld | output | N | Per-column result valid |
| dist_pass | output | N*2 | Pass tag of each result |
| dist_row | output | N*clog2(N) | Row tag of each result |
| dist_val | output | N*W | Distance result per column |

## Verification
A column whose neighbour register is out of step shows up within two clocks as a wrong result in the next column. The error is too large if a neighbour was dropped and too small if a stale or cross-pass value was used. It then spreads down the diagonal. A fault in the launch counters or in the skew chain shows up in the first cycle as a request tag that breaks the one-clock-per-column pattern, and as results arriving in the wrong cycle. Each result is checked against an independent raster-order model at the exact cycle its tags predict.

// File: rtl/dt_pkg.sv
`timescale 1ns/1ps
package dt_pkg;
  localparam int NUM_PASSES = 4;
  localparam int PASS_W     = 2;
  typedef logic [PASS_W-1:0] pass_t;
endpackage

// File: rtl/dt_launch.sv
`timescale 1ns/1ps
// Frame sequencer: issues rows 0..ROWS-1 of each pass to column 0, back to back.
module dt_launch
  import dt_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int RW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          run_vld,
  output pass_t         run_pass,
  output logic [RW-1:0] run_row
);
  localparam logic [RW-1:0] LAST_ROW  = RW'(ROWS - 1);
  localparam pass_t         LAST_PASS = PASS_W'(NUM_PASSES - 1);

  logic launch_ev, row_wrap_ev, frame_end_ev;

  assign launch_ev    = go && !run_vld;
  assign row_wrap_ev  = run_vld && (run_row == LAST_ROW);
  assign frame_end_ev = row_wrap_ev && (run_pass == LAST_PASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_vld  <= 1'b0;
      run_pass <= '0;
      run_row  <= '0;
    end else if (launch_ev) begin
      run_vld  <= 1'b1;
      run_pass <= '0;
      run_row  <= '0;
    end else if (run_vld) begin
      if (row_wrap_ev) begin
        run_row <= '0;
        if (frame_end_ev) run_vld  <= 1'b0;
        else              run_pass <= run_pass + pass_t'(1);
      end else begin
        run_row <= run_row + RW'(1);
      end
    end
  end

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_vld && $past(run_vld) && run_row != '0) |-> run_row == $past(run_row) + RW'(1)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run_vld && $past(run_vld)) |-> !(run_row == '0 && run_pass == '0)); // R9
endmodule

// File: rtl/dt_pe.sv
`timescale 1ns/1ps
// One column: stage 1 folds in the diagonal neighbour, stage 2 the straight one.
module dt_pe
  import dt_pkg::*;
#(
  parameter int W        = 8,
  parameter int RW       = 3,
  parameter int DIAG_W   = 4,
  parameter int ORTH_W   = 3,
  parameter bit HAS_LEFT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tag_vld,
  input  pass_t         tag_pass,
  input  logic [RW-1:0] tag_row,
  input  logic [W-1:0]  pix,
  input  logic          nb_vld,
  input  pass_t         nb_pass,
  input  logic [RW-1:0] nb_row,
  input  logic [W-1:0]  nb_val,
  output logic          out_vld,
  output pass_t         out_pass,
  output logic [RW-1:0] out_row,
  output logic [W-1:0]  out_val
);
  localparam logic [W-1:0] VMAX   = '1;
  localparam logic [W-1:0] DIAG_K = W'(DIAG_W);
  localparam logic [W-1:0] ORTH_K = W'(ORTH_W);
  localparam logic [RW:0]  ONE_R  = (RW+1)'(1);

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W] ? VMAX : s[W-1:0];
  endfunction

  function automatic logic [W-1:0] min_of(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic          s1_vld;
  pass_t         s1_pass;
  logic [RW-1:0] s1_row;
  logic [W-1:0]  s1_val;

  logic         diag_hit, orth_hit;
  logic [W-1:0] diag_sum, orth_sum, stage1_val, stage2_val;

  always_comb begin
    diag_hit   = HAS_LEFT && nb_vld && (nb_pass == tag_pass) &&
                 (({1'b0, nb_row} + ONE_R) == {1'b0, tag_row});
    diag_sum   = diag_hit ? sat_add(nb_val, DIAG_K) : VMAX;
    stage1_val = min_of(pix, diag_sum);
    orth_hit   = HAS_LEFT && nb_vld && (nb_pass == s1_pass) && (nb_row == s1_row);
    orth_sum   = orth_hit ? sat_add(nb_val, ORTH_K) : VMAX;
    stage2_val = min_of(s1_val, orth_sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_pass  <= '0;
      s1_row   <= '0;
      s1_val   <= '0;
      out_vld  <= 1'b0;
      out_pass <= '0;
      out_row  <= '0;
      out_val  <= '0;
    end else begin
      s1_vld   <= tag_vld;
      s1_pass  <= tag_pass;
      s1_row   <= tag_row;
      s1_val   <= stage1_val;
      out_vld  <= s1_vld;
      out_pass <= s1_pass;
      out_row  <= s1_row;
      out_val  <= stage2_val;
    end
  end

  AST_OUT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($past(tag_vld, 2) && out_row == $past(tag_row, 2) && out_pass == $past(tag_pass, 2))); // R4
  AST_NOT_ABOVE_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_val <= $past(pix, 2)); // R5
  AST_NB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && nb_vld && nb_pass == s1_pass) |-> nb_row == s1_row); // R3

  if (!HAS_LEFT) begin : g_edge
    AST_EDGE_COL: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> out_val == $past(pix, 2)); // R6
  end
endmodule

// File: rtl/dt_pass_array.sv
`timescale 1ns/1ps
module dt_pass_array
  import dt_pkg::*;
#(
  parameter int N      = 8,
  parameter int W      = 8,
  parameter int DIAG_W = 4,
  parameter int ORTH_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  logic [N*W-1:0]            pix_in,
  output logic [N-1:0]              issue_vld,
  output logic [N*PASS_W-1:0]       issue_pass,
  output logic [N*$clog2(N)-1:0]    issue_row,
  output logic [N-1:0]              dist_vld,
  output logic [N*PASS_W-1:0]       dist_pass,
  output logic [N*$clog2(N)-1:0]    dist_row,
  output logic [N*W-1:0]            dist_val
);
  localparam int RW = $clog2(N);

  logic          l_vld;
  pass_t         l_pass;
  logic [RW-1:0] l_row;

  logic          tr_vld  [1:N-1];
  pass_t         tr_pass [1:N-1];
  logic [RW-1:0] tr_row  [1:N-1];

  logic          tg_vld  [N];
  pass_t         tg_pass [N];
  logic [RW-1:0] tg_row  [N];

  logic          o_vld  [N];
  pass_t         o_pass [N];
  logic [RW-1:0] o_row  [N];
  logic [W-1:0]  o_val  [N];

  dt_launch #(.ROWS(N), .RW(RW)) u_launch (
    .clk(clk), .rst_n(rst_n), .go(go),
    .run_vld(l_vld), .run_pass(l_pass), .run_row(l_row)
  );

  // Request tags ride one column further each clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int x = 1; x < N; x++) begin
        tr_vld[x]  <= 1'b0;
        tr_pass[x] <= '0;
        tr_row[x]  <= '0;
      end
    end else begin
      for (int x = 1; x < N; x++) begin
        tr_vld[x]  <= tg_vld[x-1];
        tr_pass[x] <= tg_pass[x-1];
        tr_row[x]  <= tg_row[x-1];
      end
    end
  end

  always_comb begin
    tg_vld[0]  = l_vld;
    tg_pass[0] = l_pass;
    tg_row[0]  = l_row;
    for (int x = 1; x < N; x++) begin
      tg_vld[x]  = tr_vld[x];
      tg_pass[x] = tr_pass[x];
      tg_row[x]  = tr_row[x];
    end
  end

  for (genvar gx = 0; gx < N; gx++) begin : g_col
    if (gx == 0) begin : g_first
      dt_pe #(.W(W), .RW(RW), .DIAG_W(DIAG_W), .ORTH_W(ORTH_W), .HAS_LEFT(1'b0)) u_pe (
        .clk(clk), .rst_n(rst_n),
        .tag_vld(tg_vld[gx]), .tag_pass(tg_pass[gx]), .tag_row(tg_row[gx]),
        .pix(pix_in[gx*W +: W]),
        .nb_vld(1'b0), .nb_pass('0), .nb_row('0), .nb_val('0),
        .out_vld(o_vld[gx]), .out_pass(o_pass[gx]), .out_row(o_row[gx]), .out_val(o_val[gx])
      );
    end else begin : g_rest
      dt_pe #(.W(W), .RW(RW), .DIAG_W(DIAG_W), .ORTH_W(ORTH_W), .HAS_LEFT(1'b1)) u_pe (
        .clk(clk), .rst_n(rst_n),
        .tag_vld(tg_vld[gx]), .tag_pass(tg_pass[gx]), .tag_row(tg_row[gx]),
        .pix(pix_in[gx*W +: W]),
        .nb_vld(o_vld[gx-1]), .nb_pass(o_pass[gx-1]), .nb_row(o_row[gx-1]), .nb_val(o_val[gx-1]),
        .out_vld(o_vld[gx]), .out_pass(o_pass[gx]), .out_row(o_row[gx]), .out_val(o_val[gx])
      );
    end
    assign issue_vld[gx]                 = tg_vld[gx];
    assign issue_pass[gx*PASS_W +: PASS_W] = tg_pass[gx];
    assign issue_row[gx*RW +: RW]        = tg_row[gx];
    assign dist_vld[gx]                  = o_vld[gx];
    assign dist_pass[gx*PASS_W +: PASS_W] = o_pass[gx];
    assign dist_row[gx*RW +: RW]         = o_row[gx];
    assign dist_val[gx*W +: W]           = o_val[gx];
  end
endmodule

// File: tb/dt_pass_array_test.sv
`timescale 1ns/1ps
module dt_pass_array_test;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int RW = $clog2(N);
  localparam int PW = 2;
  localparam int NP = 4;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [N*W-1:0]  pix_in = '0;
  logic [N-1:0]    issue_vld, dist_vld;
  logic [N*PW-1:0] issue_pass, dist_pass;
  logic [N*RW-1:0] issue_row, dist_row;
  logic [N*W-1:0]  dist_val;

  dt_pass_array #(.N(N), .W(W), .DIAG_W(4), .ORTH_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .pix_in(pix_in),
    .issue_vld(issue_vld), .issue_pass(issue_pass), .issue_row(issue_row),
    .dist_vld(dist_vld), .dist_pass(dist_pass), .dist_row(dist_row), .dist_val(dist_val)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int img   [NP][N][N];
  int ref_d [NP][N][N];
  int go_cyc = -1000, stray_cyc = -1000, out_cnt = 0, last_out = 0;
  int prev_enc [N];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int sat8(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int enc(input logic v, input int p, input int r);
    return v ? (65536 + p * 256 + r) : 0;
  endfunction

  function automatic string lbl(input int p, input int y, input int x);
    if (x == 0) return "R6";
    if (p == 2 && y == 0) return "R8";
    if (p == 0) return "R7";
    return "R5";
  endfunction

  // Raster-order model of one pass per image.
  task automatic build_ref();
    for (int p = 0; p < NP; p++)
      for (int y = 0; y < N; y++)
        for (int x = 0; x < N; x++) begin
          int v = img[p][y][x];
          if (x > 0) begin
            if (y > 0) v = mn(v, sat8(ref_d[p][y-1][x-1] + 4));
            v = mn(v, sat8(ref_d[p][y][x-1] + 3));
          end
          ref_d[p][y][x] = v;
        end
  endtask

  task automatic step();
    @(negedge clk);
    for (int x = 0; x < N; x++) begin
      if (dist_vld[x]) begin
        int p = int'(dist_pass[x*PW +: PW]);
        int y = int'(dist_row[x*RW +: RW]);
        out_cnt++;
        last_out = cyc;
        check(lbl(p, y, x), int'(dist_val[x*W +: W]), ref_d[p][y][x]);
        check("R4", cyc, go_cyc + 3 + x + p * N + y);
      end
    end
    for (int x = 1; x < N; x++)
      check("R3", enc(issue_vld[x], int'(issue_pass[x*PW +: PW]), int'(issue_row[x*RW +: RW])),
            prev_enc[x-1]);
    begin
      int k = cyc - go_cyc - 1;
      int e = (k >= 0 && k < NP * N) ? enc(1'b1, k / N, k % N) : 0;
      check((cyc > stray_cyc && cyc <= stray_cyc + 3) ? "R9" : "R2",
            enc(issue_vld[0], int'(issue_pass[0 +: PW]), int'(issue_row[0 +: RW])), e);
    end
    for (int x = 0; x < N; x++) begin
      int p = int'(issue_pass[x*PW +: PW]);
      int r = int'(issue_row[x*RW +: RW]);
      pix_in[x*W +: W] = issue_vld[x] ? 8'(img[p][r][x]) : 8'h00;
      prev_enc[x] = enc(issue_vld[x], p, r);
    end
  endtask

  task automatic run_frame(input bit stray);
    out_cnt = 0;
    build_ref();
    step();
    go = 1'b1;
    go_cyc = cyc;
    for (int i = 0; i < 5 * N + 4; i++) begin
      step();
      go = stray && (i == N + 2);
      if (go) stray_cyc = cyc;
    end
    go = 1'b0;
    check("R2", out_cnt, NP * N * N);
    check("R10", last_out, go_cyc + 5 * N + 1);
    step();
    check("R2", int'(issue_vld), 0);
    check("R2", int'(dist_vld), 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0d17));
    for (int x = 0; x < N; x++) prev_enc[x] = 0;
    repeat (4) @(negedge clk);
    check("R1", int'(issue_vld), 0);
    check("R1", int'(dist_vld), 0);
    rst_n = 1'b1;
    step();
    check("R1", int'(issue_vld), 0);
    check("R1", int'(dist_vld), 0);

    // Frame 1: directed corner images.
    for (int y = 0; y < N; y++)
      for (int x = 0; x < N; x++) begin
        img[0][y][x] = 255;                                              // R7 saturation
        img[1][y][x] = (y == N - 1) ? 0 : (($urandom % 3 == 0) ? 0 : 255); // ends on background row
        img[2][y][x] = (y == N - 1 && x == N - 1) ? 0 : 255;             // R8 isolation
        img[3][y][x] = int'($urandom % 256);
      end
    run_frame(1'b1);

    // Frame 2: random binary and graded images.
    for (int p = 0; p < NP; p++)
      for (int y = 0; y < N; y++)
        for (int x = 0; x < N; x++)
          img[p][y][x] = (p == 3) ? int'($urandom % 256) : (($urandom % 4 == 0) ? 0 : 255);
    run_frame(1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule